// File: doc/BRIEF.md
# Capacitive Divider Scan Sequencer

This block drives a capacitive-divider touch measurement across a list of sense channels. Each channel is one record. For each record the block runs a short command list that sets how the channel's sense pin and two transmit pin groups are driven, and which internal capacitor switches are closed. Each command waits on a timer, on the end of an ADC conversion, or on nothing before the next command starts. A record is normally two mirrored half-cycles. Each half-cycle charges or discharges the divider, opens every switch, balances the capacitor onto the sensor and then converts. The second half-cycle uses the opposite polarities so that common-mode error cancels.

Software arms the block by raising the arm input and starts a scan by lowering it. The block then walks every record in order and raises one interrupt pulse after the last record. The ADC is outside the block and is reached through a start/done pulse pair. The analog switches are outside the block and are driven from plain control outputs. The command list is a static configuration word vector of `NCMD` entries, each 16 bits wide.

Top module: `cdiv_scan_seq`

## Requirements
- R1: After reset, and whenever no scan is running, every sense pin is driven low (`sense_oe` all ones, `sense_out` all zeros). In that state `bal_sel`, both transmit groups, both capacitor controls, `adc_start`, `math_start` and `scan_irq` are all low.
- R2: Each of the three pin drive fields in a command holds a 2-bit code: 1 drives low, 2 drives high, 3 releases the pin (oe=0), and 0 is treated as drive low. The sense field is bits [1:0], transmit group A is bits [3:2] and transmit group B is bits [5:4].
- R3: The wait field is bits [12:10]. A value of 1 holds the command for `TMRA` cycles (16 by default) and 2 holds it for `TMRB` cycles (32 by default). A value of 4 waits for a conversion. Every other value, 0 included, holds the command for exactly one cycle.
- R4: When the convert bit (bit 9) is set, `adc_start` pulses high for the first cycle of the command only. A wait value of 4 holds the command until `adc_done` is high in a later cycle, and the command ends in that cycle.
- R5: The math bit (bit 13) pulses `math_start` on the first cycle of the command. `math_second` is high in that same cycle when bit 14 is set.
- R6: The charge bit (6) and the discharge bit (7) drive `cap_chg` and `cap_dis` for the whole command. The balance bit (8) closes only the balance switch of the current record's channel (`bal_sel` is at most one-hot).
- R7: During record r, the sense drive code acts on sense pin r only, and every other sense pin stays driven low.
- R8: Commands run in index order from 0. A record ends after command `NCMD`-1, or earlier after a command whose end bit (bit 15) is set.
- R9: Records 0 to `NREC`-1 run back to back. In the cycle after the final command of the last record, `scan_irq` is high for exactly one cycle and the block is idle.
- R10: A scan starts when `arm` is sampled low after it has been sampled high while idle. The first command is presented in the cycle after the clock edge that sees `arm` low.
- R11: Movements of `arm` during a scan have no effect on the scan. After a scan the block does not start again until `arm` has been sampled high while idle and then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Software arm bit; a falling edge after being armed starts a scan |
| adc_done | input | 1 | End-of-conversion pulse from the ADC |
| cmd_list | input | NCMD*16 | Command words; command k is bits [16k+15:16k] |
| sense_oe | output | NREC | Sense pin output enables |
| sense_out | output | NREC | Sense pin drive levels |
| bal_sel | output | NREC | Balance switch per channel |
| tx_a_oe | output | 1 | Transmit group A enable |
| tx_a_lvl | output | 1 | Transmit group A level |
| tx_b_oe | output | 1 | Transmit group B enable |
| tx_b_lvl | output | 1 | Transmit group B level |
| cap_chg | output | 1 | Capacitor charge switch |
| cap_dis | output | 1 | Capacitor discharge switch |
| adc_start | output | 1 | Conversion start pulse |
| math_start | output | 1 | Math pass request pulse |
| math_second | output | 1 | Marks the math request as the second pass |
| scan_irq | output | 1 | One-cycle end-of-scan interrupt |

## Verification
Some properties are checked on every cycle. When no scan is running, all pins are low and all strobes are off. No more than one sense pin is ever released, and the balance select is never more than one-hot. A conversion start lasts one cycle, and a conversion command holds until the done pulse arrives. The interrupt lasts one cycle and leaves the block idle. Other behaviour can only be shown by the bench's scenarios. These are the exact dwell times of each command and the record-to-pin mapping across all 32 records. They also include the early end of a record on its end bit, the treatment of unlisted wait values, and the ignoring of arm edges both during a scan and after it when the block has not been re-armed.

// File: rtl/cdiv_scan_seq.sv
module cdiv_scan_seq #(
  parameter int NREC = 32,
  parameter int NCMD = 8,
  parameter int TMRA = 16,
  parameter int TMRB = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic               adc_done,
  input  logic [NCMD*16-1:0] cmd_list,
  output logic [NREC-1:0]    sense_oe,
  output logic [NREC-1:0]    sense_out,
  output logic [NREC-1:0]    bal_sel,
  output logic               tx_a_oe,
  output logic               tx_a_lvl,
  output logic               tx_b_oe,
  output logic               tx_b_lvl,
  output logic               cap_chg,
  output logic               cap_dis,
  output logic               adc_start,
  output logic               math_start,
  output logic               math_second,
  output logic               scan_irq
);
  localparam int CW   = 16;
  localparam int RW   = (NREC > 1) ? $clog2(NREC) : 1;
  localparam int SW   = (NCMD > 1) ? $clog2(NCMD) : 1;
  localparam int TMAX = (TMRA > TMRB) ? TMRA : TMRB;
  localparam int TW   = $clog2(TMAX + 1) + 1;

  localparam int F_SNS = 0, F_TXA = 2, F_TXB = 4, F_CHG = 6, F_DIS = 7;
  localparam int F_BAL = 8, F_CNV = 9, F_WT = 10, F_MS = 13, F_SEC = 14, F_END = 15;

  logic          running, armed, irq_q;
  logic [RW-1:0] rec;
  logic [SW-1:0] step;
  logic [TW-1:0] cnt;
  logic [CW-1:0] cmd;
  logic          step_done;

  assign cmd = cmd_list[step*CW +: CW];

  function automatic logic [1:0] drv(input logic [1:0] code);
    case (code)
      2'd2:    drv = 2'b11;
      2'd3:    drv = 2'b00;
      default: drv = 2'b10;
    endcase
  endfunction

  always_comb begin
    case (cmd[F_WT +: 3])
      3'd1:    step_done = (cnt == TW'(TMRA - 1));
      3'd2:    step_done = (cnt == TW'(TMRB - 1));
      3'd4:    step_done = adc_done && (cnt != '0);
      default: step_done = 1'b1;
    endcase
  end

  wire first    = running && (cnt == '0);
  wire rec_end  = cmd[F_END] || (step == SW'(NCMD - 1));
  wire scan_end = (rec == RW'(NREC - 1));
  wire start    = !running && armed && !arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      armed   <= 1'b0;
      irq_q   <= 1'b0;
      rec     <= '0;
      step    <= '0;
      cnt     <= '0;
    end else begin
      irq_q <= 1'b0;
      if (!running) begin
        if (arm) armed <= 1'b1;
        if (start) begin
          running <= 1'b1;
          armed   <= 1'b0;
          rec     <= '0;
          step    <= '0;
          cnt     <= '0;
        end
      end else if (step_done) begin
        cnt <= '0;
        if (rec_end) begin
          step <= '0;
          if (scan_end) begin
            running <= 1'b0;
            irq_q   <= 1'b1;
            rec     <= '0;
          end else begin
            rec <= rec + 1'b1;
          end
        end else begin
          step <= step + 1'b1;
        end
      end else if (cnt != '1) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  wire [1:0] d_sns = drv(cmd[F_SNS +: 2]);
  wire [1:0] d_txa = drv(cmd[F_TXA +: 2]);
  wire [1:0] d_txb = drv(cmd[F_TXB +: 2]);

  for (genvar i = 0; i < NREC; i++) begin : g_pin
    wire sel = running && (rec == RW'(i));
    assign sense_oe[i]  = sel ? d_sns[1] : 1'b1;
    assign sense_out[i] = sel ? d_sns[0] : 1'b0;
    assign bal_sel[i]   = sel && cmd[F_BAL];
  end

  assign tx_a_oe     = running && d_txa[1];
  assign tx_a_lvl    = running && d_txa[0];
  assign tx_b_oe     = running && d_txb[1];
  assign tx_b_lvl    = running && d_txb[0];
  assign cap_chg     = running && cmd[F_CHG];
  assign cap_dis     = running && cmd[F_DIS];
  assign adc_start   = first && cmd[F_CNV];
  assign math_start  = first && cmd[F_MS];
  assign math_second = math_start && cmd[F_SEC];
  assign scan_irq    = irq_q;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (&sense_oe && sense_out == '0 && bal_sel == '0 && !adc_start && !math_start
                  && !tx_a_oe && !tx_b_oe && !cap_chg && !cap_dis));

  p_one_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sense_oe) <= 1);

  p_bal_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bal_sel));

  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && cmd[F_WT +: 3] == 3'd4) |=> !adc_start);

  p_conv_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cmd[F_WT +: 3] == 3'd4 && cnt != '0 && !adc_done)
      |=> (running && $stable(step) && $stable(rec)));

  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    scan_irq |=> !scan_irq);

  p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    scan_irq |-> (!running && $past(running) && $past(rec) == RW'(NREC - 1)));
endmodule

// File: tb/test_cdiv_scan_seq.sv
module test_cdiv_scan_seq;
  localparam int NREC = 32;
  localparam int NCMD = 8;
  localparam int DLY  = 3;

  // {command word, expected {sns_oe,sns_lvl,a_oe,a_lvl,b_oe,b_lvl,chg,dis,bal,cnv,ms,sec}, cycles}
  localparam logic [35:0] VEC [NCMD] = '{
    {16'h0465, 12'b101011100000, 8'd16},
    {16'h0027, 12'b001011000000, 8'd1},
    {16'h0927, 12'b001011001000, 8'd32},
    {16'h3227, 12'b001011000110, 8'(DLY + 1)},
    {16'h049A, 12'b111110010000, 8'd16},
    {16'h001B, 12'b001110000000, 8'd1},
    {16'h091B, 12'b001110001000, 8'd32},
    {16'hF21B, 12'b001110000111, 8'(DLY + 1)}
  };

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, adc_done = 1'b0;
  logic [NCMD*16-1:0] cmd_list;
  logic [NREC-1:0] sense_oe, sense_out, bal_sel;
  logic tx_a_oe, tx_a_lvl, tx_b_oe, tx_b_lvl, cap_chg, cap_dis;
  logic adc_start, math_start, math_second, scan_irq;
  int checks = 0, fails = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  cdiv_scan_seq #(.NREC(NREC), .NCMD(NCMD), .TMRA(16), .TMRB(32)) i_cdiv_scan_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm), .adc_done(adc_done), .cmd_list(cmd_list),
    .sense_oe(sense_oe), .sense_out(sense_out), .bal_sel(bal_sel),
    .tx_a_oe(tx_a_oe), .tx_a_lvl(tx_a_lvl), .tx_b_oe(tx_b_oe), .tx_b_lvl(tx_b_lvl),
    .cap_chg(cap_chg), .cap_dis(cap_dis), .adc_start(adc_start),
    .math_start(math_start), .math_second(math_second), .scan_irq(scan_irq));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [11:0] obs(input int r);
    obs = {sense_oe[r], sense_out[r], tx_a_oe, tx_a_lvl, tx_b_oe, tx_b_lvl,
           cap_chg, cap_dis, bal_sel[r], adc_start, math_start, math_second};
  endfunction

  task automatic check_idle(input string req);
    check(&sense_oe && sense_out == '0 && bal_sel == '0 && !adc_start && !tx_a_oe && !tx_b_oe
          && !cap_chg && !cap_dis && !math_start,
          req, {sense_oe, sense_out}, {{NREC{1'b1}}, {NREC{1'b0}}});
  endtask

  task automatic trigger();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < NCMD; k++) cmd_list[k*16 +: 16] = VEC[k][35:20];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 reset state");
    check(!scan_irq, "R1 irq after reset", scan_irq, 0);

    repeat (20) @(negedge clk);
    check_idle("R10 no start without arm");

    // Full scan walked against the vector table
    trigger();
    for (int r = 0; r < NREC; r++) begin
      for (int s = 0; s < NCMD; s++) begin
        int dur;
        logic [11:0] exp;
        dur = int'(VEC[s][7:0]);
        exp = VEC[s][19:8];
        adc_done = 1'b0;
        check(obs(r) == exp, $sformatf("R2 R5 R6 R7 rec %0d step %0d entry", r, s), obs(r), exp);
        check((sense_oe | (NREC'(1) << r)) == '1 && (sense_out & ~(NREC'(1) << r)) == '0,
              "R7 other pins low", {sense_oe, sense_out}, r);
        for (int c = 1; c < dur; c++) begin
          @(negedge clk);
          if (r == 5 && s == 2 && c == 4)  arm = 1'b1;
          if (r == 5 && s == 2 && c == 10) arm = 1'b0;
          if (c == dur - 1) begin
            if (exp[2]) adc_done = 1'b1;
            check(obs(r) == (exp & 12'hFF8), $sformatf("R3 R4 rec %0d step %0d hold", r, s),
                  obs(r), exp & 12'hFF8);
          end
        end
        @(negedge clk);
      end
    end
    adc_done = 1'b0;
    check(scan_irq == 1'b1, "R9 irq after last record", scan_irq, 1);
    check_idle("R9 idle after scan");
    @(negedge clk);
    check(scan_irq == 1'b0, "R9 irq single cycle", scan_irq, 0);
    begin
      int starts = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (adc_start || !(&sense_oe)) starts++;
      end
      check(starts == 0, "R11 no restart without re-arm", starts, 0);
    end

    // Second scan: end bit on command 3, odd wait code on command 1
    cmd_list[3*16 +: 16] = 16'hB227;
    cmd_list[1*16 +: 16] = 16'h0C27;
    trigger();
    begin
      int n = 1, dc = 0, starts = 0, seconds = 0, dis = 0;
      while (!scan_irq && n < 5000) begin
        if (adc_start) starts++;
        if (math_second) seconds++;
        if (cap_dis) dis++;
        @(negedge clk);
        adc_done = 1'b0;
        if (dc == 1) adc_done = 1'b1;
        if (dc > 0) dc--;
        if (adc_start) dc = DLY;
        n++;
      end
      check(n == 32 * (16 + 1 + 32 + DLY + 1) + 1, "R8 R3 early end scan length", n,
            32 * (16 + 1 + 32 + DLY + 1) + 1);
      check(starts == 32, "R8 one conversion per record", starts, 32);
      check(seconds == 0 && dis == 0, "R8 second half skipped", {seconds, dis}, 0);
      check(scan_irq == 1'b1, "R9 irq after short scan", scan_irq, 1);
    end
    adc_done = 1'b0;
    @(negedge clk);
    check_idle("R11 idle after second scan");

    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule